// File: doc/BRIEF.md
# Beat-Quantised Trigger Buffer

This block holds a one-shot "advance" request and releases it as a single output trigger on the next beat. It runs on a fast sample clock. Two inputs arrive from elsewhere: an advance request and a beat clock. Either input may be a short trigger or a long gate. Each one passes through a synchroniser and is then reduced to its rising edge. An advance edge arms a pending-request latch. The next beat rising edge fires a fixed-width output pulse and clears the latch, so a change requested at any moment lands exactly on a beat.

The output pulse width is a whole number of sample-clock cycles. The default is 33 cycles, about 0.7 ms at 48 kHz. A grace window of configurable length opens after each beat edge that did not release a request. An advance that arrives inside that window counts as on time and fires at once. Setting the grace length to 0 removes the window.

Top module: `trigbuf_top`

## Requirements
- R1: A synchronous active-high `rst` forces `trig_out` low and clears any pending request, any active pulse and any open grace window. A request made before reset is never released afterwards.
- R2: With no pending request, beat edges produce no output. With a request pending, the next beat rising edge releases exactly one pulse. `trig_out` goes high on the third rising clock edge after `beat_in` first reads high.
- R3: The beat input acts only through its rising edge. A request that arrives while `beat_in` is held high (outside the grace window) waits for the next low-to-high change.
- R4: The advance input acts only through its rising edge. Holding `advance_in` high across several beats yields exactly one pulse.
- R5: A second advance edge while a request is already pending has no effect. At most one pulse follows one beat.
- R6: Each output pulse is active-high for exactly `PULSE_CYCLES` consecutive cycles (default 33).
- R7: When advance and beat rising edges are detected in the same cycle, a pulse is released and no request is left pending for the following beat.
- R8: A beat edge that releases nothing opens a grace window of `GRACE_CYCLES` cycles (default 100). An advance edge inside the window fires at once, with `trig_out` high on the third rising clock edge after `advance_in` first reads high. An advance edge after the window waits for the next beat. `GRACE_CYCLES` = 0 disables the window.
- R9: Any release closes the grace window, so a further advance soon after a released beat waits for the next beat edge.
- R10: A beat edge during an active pulse neither restarts nor lengthens it. A request pending at that moment stays pending for a later beat edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| advance_in | input | 1 | Request input, trigger or gate, asynchronous |
| beat_in | input | 1 | Beat clock input, trigger or gate, asynchronous |
| trig_out | output | 1 | Released trigger pulse, `PULSE_CYCLES` wide |

## Verification
A latch that stays set after a release would show up as a second pulse on the very next beat edge. A latch that never sets would show up as a missing pulse three cycles after the beat. A pulse counter that reloads or miscounts shows up as a wrong high-time, visible when the pulse ends, at most `PULSE_CYCLES` cycles after release. A grace timer that is too long, never cleared, or never loaded shows up as an early or late release, three cycles after an advance edge. The bench compares `trig_out` against a behavioural model on every cycle, so any such fault is reported in the cycle where it first reaches the port.

// File: rtl/trigbuf_pkg.sv
package trigbuf_pkg;
  // bits needed to hold a down-counter preset of n (at least one bit)
  function automatic int cnt_width(int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // release decision: fresh beat with a request, or late request in grace
  function automatic logic release_now(logic busy, logic armed, logic adv_rise,
                                       logic beat_rise, logic grace_open);
    return !busy && ((beat_rise && (armed || adv_rise)) || (adv_rise && grace_open));
  endfunction
endpackage

// File: rtl/trigbuf_edge.sv
module trigbuf_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/trigbuf_arm.sv
module trigbuf_arm
  import trigbuf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv_rise,
  input  logic beat_rise,
  input  logic grace_open,
  input  logic busy,
  output logic armed,
  output logic fire
);
  always_comb fire = release_now(busy, armed, adv_rise, beat_rise, grace_open);

  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b0;
    else if (fire)     armed <= 1'b0;
    else if (adv_rise) armed <= 1'b1;
  end
endmodule

// File: rtl/trigbuf_pulse.sv
module trigbuf_pulse
  import trigbuf_pkg::*;
#(
  parameter int PULSE_CYCLES = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic busy
);
  localparam int W = cnt_width(PULSE_CYCLES);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                        left_q <= '0;
    else if (fire && left_q == '0)  left_q <= W'(PULSE_CYCLES);
    else if (left_q != '0)          left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/trigbuf_grace.sv
module trigbuf_grace
  import trigbuf_pkg::*;
#(
  parameter int GRACE_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic beat_rise,
  input  logic fire,
  output logic grace_open
);
  localparam int W = cnt_width(GRACE_CYCLES);
  logic [W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst)                 win_q <= '0;
    else if (fire)           win_q <= '0;
    else if (beat_rise)      win_q <= W'(GRACE_CYCLES);
    else if (win_q != '0)    win_q <= win_q - 1'b1;
  end

  assign grace_open = (win_q != '0);
endmodule

// File: rtl/trigbuf_top.sv
module trigbuf_top #(
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 33,
  parameter int GRACE_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic advance_in,
  input  logic beat_in,
  output logic trig_out
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] rise_vec;
  logic adv_rise, beat_rise, armed, fire, busy, grace_open;

  assign raw_in = {beat_in, advance_in};

  for (genvar i = 0; i < NUM_IN; i++) begin : gen_edge
    trigbuf_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .din(raw_in[i]), .rise(rise_vec[i])
    );
  end

  assign adv_rise  = rise_vec[0];
  assign beat_rise = rise_vec[1];

  trigbuf_arm u_arm (
    .clk(clk), .rst(rst), .adv_rise(adv_rise), .beat_rise(beat_rise),
    .grace_open(grace_open), .busy(busy), .armed(armed), .fire(fire)
  );

  trigbuf_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .busy(busy)
  );

  trigbuf_grace #(.GRACE_CYCLES(GRACE_CYCLES)) u_grace (
    .clk(clk), .rst(rst), .beat_rise(beat_rise), .fire(fire), .grace_open(grace_open)
  );

  assign trig_out = busy;
endmodule

// File: rtl/trigbuf_chk.sv
module trigbuf_chk #(
  parameter int PULSE_CYCLES = 33
) (
  input logic clk,
  input logic rst,
  input logic adv_rise,
  input logic beat_rise,
  input logic armed,
  input logic fire,
  input logic grace_open,
  input logic trig_out
);
  localparam int RW = $clog2(PULSE_CYCLES + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (trig_out) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // R6: pulse never outlasts its width, and ends at exactly that width
  a_r6_width_cap: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> (run_q < RW'(PULSE_CYCLES)));
  a_r6_width_exact: assert property (@(posedge clk) disable iff (rst)
    ($fell(trig_out) && !$past(rst)) |-> (run_q == RW'(PULSE_CYCLES)));
  // R2: output only starts after a release decision
  a_r2_start_after_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_out) |-> $past(fire));
  // R2 / R7: a release leaves nothing pending
  a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
    fire |=> !armed);
  // R4: the latch only sets from an advance edge
  a_r4_arm_from_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(adv_rise));
  // R3: a release needs a fresh edge of some input
  a_r3_edge_needed: assert property (@(posedge clk) disable iff (rst)
    fire |-> (beat_rise || adv_rise));
  // R9: a release closes the grace window
  a_r9_grace_closed: assert property (@(posedge clk) disable iff (rst)
    fire |=> !grace_open);
endmodule

bind trigbuf_top trigbuf_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .adv_rise(adv_rise), .beat_rise(beat_rise),
  .armed(armed), .fire(fire), .grace_open(grace_open), .trig_out(trig_out)
);

// File: tb/trigbuf_top_bench.sv
`timescale 1ns/1ps
module trigbuf_top_bench;
  localparam int PW = 33;
  localparam int GW = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic beat = 1'b0;
  logic trig_out;

  int nchecks = 0, nerr = 0, cyc = 0;
  bit done = 0;

  trigbuf_top #(.SYNC_STAGES(2), .PULSE_CYCLES(PW), .GRACE_CYCLES(GW)) u_trigbuf_top (
    .clk(clk), .rst(rst), .advance_in(adv), .beat_in(beat), .trig_out(trig_out)
  );

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: input history queues and countdown integers
  bit aq[$] = '{0, 0, 0};
  bit bq[$] = '{0, 0, 0};
  int m_pulse = 0, m_grace = 0;
  bit m_pend = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      aq = '{0, 0, 0}; bq = '{0, 0, 0};
      m_pulse = 0; m_grace = 0; m_pend = 0;
    end else begin
      bit a_r, b_r, busy, go;
      a_r = aq[1] && !aq[2];
      b_r = bq[1] && !bq[2];
      aq.push_front(adv); void'(aq.pop_back());
      bq.push_front(beat); void'(bq.pop_back());
      busy = (m_pulse > 0);
      go = !busy && ((b_r && (m_pend || a_r)) || (a_r && m_grace > 0));
      if (go) m_pulse = PW; else if (m_pulse > 0) m_pulse--;
      if (go) m_pend = 0; else if (a_r) m_pend = 1;
      if (go) m_grace = 0; else if (b_r) m_grace = GW; else if (m_grace > 0) m_grace--;
    end
  end

  // observation at the falling edge
  int pulses = 0, rise_at = 0, run = 0, last_width = 0;
  bit prev_t = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(trig_out === (m_pulse > 0), "R6 per-cycle model", int'(trig_out), int'(m_pulse > 0));
    end
    if (trig_out === 1'b1) begin
      if (!prev_t) begin pulses++; rise_at = cyc; end
      run++;
    end else begin
      if (prev_t) last_width = run;
      run = 0;
    end
    prev_t = (trig_out === 1'b1);
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      nchecks++; nerr++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic adv_tick();
    adv = 1'b1; step(1); adv = 1'b0;
  endtask
  task automatic beat_tick(int len);
    beat = 1'b1; step(len); beat = 1'b0;
  endtask

  initial begin
    int base, t0;
    step(5);
    check(trig_out === 1'b0, "R1 reset output low", int'(trig_out), 0);
    rst = 1'b0;
    step(5);

    // R2: beats alone do nothing
    base = pulses;
    beat_tick(5); step(200); beat_tick(5); step(200);
    check(pulses == base, "R2 no request no pulse", pulses - base, 0);

    // R2 / R6: one request, one pulse on the next beat, fixed latency and width
    base = pulses;
    adv_tick(); step(50);
    check(pulses == base, "R2 waits for beat", pulses - base, 0);
    t0 = cyc; beat_tick(5); step(60);
    check(pulses - base == 1, "R2 one pulse", pulses - base, 1);
    check(rise_at - t0 == 3, "R2 beat latency", rise_at - t0, 3);
    check(last_width == PW, "R6 pulse width", last_width, PW);
    step(100);

    // R3: request during a held-high beat waits for the next rising edge
    base = pulses;
    beat = 1'b1; step(150); adv_tick(); step(50);
    check(pulses == base, "R3 held beat does not release", pulses - base, 0);
    beat = 1'b0; step(10);
    t0 = cyc; beat = 1'b1; step(60);
    check(pulses - base == 1, "R3 next rise releases", pulses - base, 1);
    check(rise_at - t0 == 3, "R3 release latency", rise_at - t0, 3);
    beat = 1'b0; step(150);

    // R4: held advance arms once
    base = pulses;
    adv = 1'b1; step(20);
    for (int k = 0; k < 3; k++) begin beat_tick(5); step(150); end
    adv = 1'b0; step(150);
    check(pulses - base == 1, "R4 held advance single pulse", pulses - base, 1);

    // R5: double request before a beat
    base = pulses;
    adv_tick(); step(10); adv_tick(); step(10);
    beat_tick(5); step(150); beat_tick(5); step(60);
    check(pulses - base == 1, "R5 extra request ignored", pulses - base, 1);
    step(150);

    // R7: same-cycle edges
    base = pulses;
    adv = 1'b1; beat = 1'b1; step(1); adv = 1'b0; step(4); beat = 1'b0;
    step(60);
    check(pulses - base == 1, "R7 simultaneous fires", pulses - base, 1);
    step(100); beat_tick(5); step(60);
    check(pulses - base == 1, "R7 nothing left pending", pulses - base, 1);
    step(150);

    // R8: inside the grace window fires at once; outside waits
    base = pulses;
    beat_tick(5); step(15);
    t0 = cyc; adv_tick(); step(10);
    check(pulses - base == 1, "R8 grace release", pulses - base, 1);
    check(rise_at - t0 == 3, "R8 grace latency", rise_at - t0, 3);
    step(150);
    base = pulses;
    beat_tick(5); step(GW + 20);
    adv_tick(); step(50);
    check(pulses == base, "R8 late request waits", pulses - base, 0);
    beat_tick(5); step(60);
    check(pulses - base == 1, "R8 late request on next beat", pulses - base, 1);
    step(150);

    // R9: release closes grace
    base = pulses;
    adv_tick(); step(5); beat_tick(5); step(25);
    adv_tick(); step(40);
    check(pulses - base == 1, "R9 no second release in window", pulses - base, 1);
    beat_tick(5); step(60);
    check(pulses - base == 2, "R9 second release on next beat", pulses - base, 2);
    step(150);

    // R10: beat during an active pulse
    base = pulses;
    adv_tick(); step(5); beat_tick(3); step(7);
    adv_tick(); step(5); beat_tick(3); step(60);
    check(pulses - base == 1, "R10 no retrigger", pulses - base, 1);
    check(last_width == PW, "R10 width not extended", last_width, PW);
    step(100); beat_tick(5); step(60);
    check(pulses - base == 2, "R10 pending kept", pulses - base, 2);
    step(150);

    // R1: reset drops a pending request
    base = pulses;
    adv_tick(); step(10);
    rst = 1'b1; step(3);
    check(trig_out === 1'b0, "R1 low in reset", int'(trig_out), 0);
    rst = 1'b0; step(5);
    beat_tick(5); step(60);
    check(pulses == base, "R1 request cleared", pulses - base, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end
endmodule